// File: doc/BRIEF.md
# Four-Channel DMA Transfer Engine

This block moves single bytes between peripherals and memory on behalf of up to four requesting devices. The engine does not carry the data itself. It drives the memory address, one memory strobe and one I/O strobe, and pulls low the acknowledge of the serviced device, which acts as that device's chip select. The byte then passes directly between the peripheral and memory. Before it touches the bus, the engine asks the CPU for the bus with a hold request and waits for hold acknowledge. It releases the bus after every byte, so the CPU runs between DMA bytes.

The CPU programs the engine through an 8-bit write port. The register address is split into a kind field (upper two bits) and a channel field (lower bits):
- kind 0 is the 16-bit address.
- kind 1 is the 16-bit byte count.
- kind 2 is the per-channel mode.
- kind 3 is control.

The 16-bit registers are written as two bytes, low byte first. An internal byte pointer chooses which byte a write lands in. Writing the address or the count loads both a working copy and a base copy. Auto-initialization reloads the working copy from the base copy. The working address steps up or down by one on each byte and wraps within 16 bits. A resolver picks the channel to serve, using either fixed order or rotating order.

Top module: `dma4_engine`

## Requirements
- R1: `dreq_ni[n]` low requests service for channel n. `dack_no[n]` is low only during channel n's transfer cycle, and never more than one acknowledge is low at a time.
- R2: When an unmasked request is pending, `hrq_o` rises. `aen_o` and the acknowledges stay inactive until `hlda_i` is seen high. `aen_o` is high for exactly the one transfer cycle, during which `addr_o` carries the channel's working address.
- R3: With command bit 0 clear (control, channel field 0), the lowest-numbered pending channel wins.
- R4: With command bit 0 set, the search starts at the channel after the last one serviced, so the channel just serviced has the lowest priority. After reset the last serviced channel counts as channel 3, so channel 0 is searched first.
- R5: Each transfer decrements the working count. It also steps the working address by +1 when mode bit 1 is 0, or by −1 when it is 1, wrapping at 16 bits (0xFFFF→0x0000 and 0x0000→0xFFFF).
- R6: The transfer made when the working count is 0 is the terminal-count transfer. In that cycle `tc_o` pulses for one cycle. The channel's `status_o` bit is set, and the channel becomes masked unless mode bit 2 is set.
- R7: With mode bit 2 set, terminal count reloads the working address and count from the base copies, and the channel stays unmasked.
- R8: The byte pointer selects the low byte when 0 and the high byte when 1. It toggles on each address or count write, and it is cleared by reset or by a write to control, channel field 1.
- R9: Mode bit 0 = 0 drives `io_rd_o` and `mem_wr_o`. Mode bit 0 = 1 drives `mem_rd_o` and `io_wr_o`. All four strobes are low outside the transfer cycle.
- R10: `hrq_o` is low in the cycle after every transfer.
- R11: Reset masks every channel. A write to control, channel field 2, loads the mask from data bits [3:0], where 1 means masked. A masked channel's request leaves `hrq_o` low.
- R12: If a CPU byte write to a channel's working address or count lands in that channel's transfer cycle, the written register takes the pre-cycle value with the addressed byte replaced. The channel's other register is updated normally.
- R13: Writing a channel's mode register clears that channel's status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | CPU register write strobe |
| reg_addr_i | input | 4 | Register address {kind, channel} |
| reg_wdata_i | input | 8 | Register write data |
| dreq_ni | input | 4 | Channel requests, active low |
| dack_no | output | 4 | Channel acknowledges, active low |
| hrq_o | output | 1 | Hold request to the CPU |
| hlda_i | input | 1 | Hold acknowledge from the CPU |
| aen_o | output | 1 | Address enable, high during the transfer cycle |
| addr_o | output | 16 | Memory address during the transfer |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| io_rd_o | output | 1 | Peripheral read strobe |
| io_wr_o | output | 1 | Peripheral write strobe |
| tc_o | output | 1 | Terminal-count pulse |
| status_o | output | 4 | Per-channel terminal-count flags |

## Verification
Two functions can fall in the same cycle: the end-of-transfer update of a channel's working registers, and a CPU byte write to one of those registers. The bench provokes this by holding the write strobe during the cycle in which `aen_o` is high for that channel. It then judges the result from the address driven by the channel's next transfer. That address must show the written byte, together with the pre-cycle value of the other byte, instead of the stepped address. The terminal-count masking and the mode write that clears status can meet in the same way; in both collisions the CPU write has the last word.

// File: rtl/dma4_pkg.sv
package dma4_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_XFER} dma_state_e;

  localparam logic [1:0] K_ADDR = 2'd0;
  localparam logic [1:0] K_CNT  = 2'd1;
  localparam logic [1:0] K_MODE = 2'd2;
  localparam logic [1:0] K_CTRL = 2'd3;

  localparam int CTRL_CMD    = 0;
  localparam int CTRL_CLRPTR = 1;
  localparam int CTRL_MASK   = 2;

  localparam int MODE_W    = 3;
  localparam int MODE_DIR  = 0;
  localparam int MODE_DEC  = 1;
  localparam int MODE_AUTO = 2;
  localparam int CMD_ROT   = 0;
endpackage

// File: rtl/dma4_regs.sv
module dma4_regs
  import dma4_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 8,
  localparam int CH_W   = $clog2(NUM_CH),
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           wr_i,
  input  logic [CH_W+1:0]                waddr_i,
  input  logic [DATA_W-1:0]              wdata_i,
  input  logic                           upd_i,
  input  logic [CH_W-1:0]                upd_ch_i,
  output logic [NUM_CH-1:0][ADDR_W-1:0]  cur_addr_o,
  output logic [NUM_CH-1:0][ADDR_W-1:0]  cur_cnt_o,
  output logic [NUM_CH-1:0]              dir_o,
  output logic [NUM_CH-1:0]              mask_o,
  output logic                           rotate_o,
  output logic [NUM_CH-1:0]              status_o
);
  logic [NUM_CH-1:0][ADDR_W-1:0] base_a, base_c, cur_a, cur_c;
  logic [NUM_CH-1:0][MODE_W-1:0] mode;
  logic [NUM_CH-1:0]             mask, status;
  logic                          rot, ptr;

  logic [1:0]      kind;
  logic [CH_W-1:0] wch;
  assign kind = waddr_i[CH_W+1:CH_W];
  assign wch  = waddr_i[CH_W-1:0];

  logic [ADDR_W-1:0] step_a;
  logic              at_tc;
  assign step_a = mode[upd_ch_i][MODE_DEC] ? cur_a[upd_ch_i] - ADDR_W'(1)
                                           : cur_a[upd_ch_i] + ADDR_W'(1);
  assign at_tc  = (cur_c[upd_ch_i] == '0);

  function automatic logic [ADDR_W-1:0] put_byte(logic [ADDR_W-1:0] old,
                                                  logic hi, logic [DATA_W-1:0] d);
    return hi ? {d, old[DATA_W-1:0]} : {old[ADDR_W-1:DATA_W], d};
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_a <= '0;
      base_c <= '0;
      cur_a  <= '0;
      cur_c  <= '0;
      mode   <= '0;
      mask   <= '1;
      status <= '0;
      rot    <= 1'b0;
      ptr    <= 1'b0;
    end else begin
      if (upd_i) begin
        if (at_tc) begin
          status[upd_ch_i] <= 1'b1;
          if (mode[upd_ch_i][MODE_AUTO]) begin
            cur_a[upd_ch_i] <= base_a[upd_ch_i];
            cur_c[upd_ch_i] <= base_c[upd_ch_i];
          end else begin
            mask[upd_ch_i]  <= 1'b1;
            cur_a[upd_ch_i] <= step_a;
            cur_c[upd_ch_i] <= cur_c[upd_ch_i] - ADDR_W'(1);
          end
        end else begin
          cur_a[upd_ch_i] <= step_a;
          cur_c[upd_ch_i] <= cur_c[upd_ch_i] - ADDR_W'(1);
        end
      end
      // CPU write is applied last so it wins over the transfer update
      if (wr_i) begin
        unique case (kind)
          K_ADDR: begin
            base_a[wch] <= put_byte(base_a[wch], ptr, wdata_i);
            cur_a[wch]  <= put_byte(cur_a[wch], ptr, wdata_i);
            ptr         <= ~ptr;
          end
          K_CNT: begin
            base_c[wch] <= put_byte(base_c[wch], ptr, wdata_i);
            cur_c[wch]  <= put_byte(cur_c[wch], ptr, wdata_i);
            ptr         <= ~ptr;
          end
          K_MODE: begin
            mode[wch]   <= wdata_i[MODE_W-1:0];
            status[wch] <= 1'b0;
          end
          default: begin
            if (int'(wch) == CTRL_CMD)    rot  <= wdata_i[CMD_ROT];
            if (int'(wch) == CTRL_CLRPTR) ptr  <= 1'b0;
            if (int'(wch) == CTRL_MASK)   mask <= wdata_i[NUM_CH-1:0];
          end
        endcase
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_CH; i++) dir_o[i] = mode[i][MODE_DIR];
  end

  assign cur_addr_o = cur_a;
  assign cur_cnt_o  = cur_c;
  assign mask_o     = mask;
  assign rotate_o   = rot;
  assign status_o   = status;
endmodule

// File: rtl/dma4_arb.sv
module dma4_arb #(
  parameter int NUM_CH = 4,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] req_i,
  input  logic              rotate_i,
  input  logic              adv_i,
  input  logic [CH_W-1:0]   adv_ch_i,
  output logic              valid_o,
  output logic [CH_W-1:0]   win_o
);
  logic [CH_W-1:0] last_q, start, idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    last_q <= CH_W'(NUM_CH - 1);
    else if (adv_i) last_q <= adv_ch_i;
  end

  assign start = rotate_i ? last_q + CH_W'(1) : '0;

  // Walk from the far end toward start so the first in search order wins
  always_comb begin
    win_o = '0;
    idx   = '0;
    for (int k = NUM_CH - 1; k >= 0; k--) begin
      idx = start + CH_W'(k);
      if (req_i[idx]) win_o = idx;
    end
  end

  assign valid_o = |req_i;
endmodule

// File: rtl/dma4_seq.sv
module dma4_seq
  import dma4_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            pend_i,
  input  logic [CH_W-1:0] win_i,
  input  logic            hlda_i,
  output logic            hrq_o,
  output logic            aen_o,
  output logic [CH_W-1:0] ch_o,
  output logic            upd_o
);
  dma_state_e st_q, st_d;
  logic [CH_W-1:0] ch_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (pend_i) st_d = ST_REQ;
      ST_REQ: begin
        if (!pend_i)     st_d = ST_IDLE;
        else if (hlda_i) st_d = ST_XFER;
      end
      default:           st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE;
      ch_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_REQ && pend_i && hlda_i) ch_q <= win_i;
    end
  end

  assign hrq_o = (st_q != ST_IDLE);
  assign aen_o = (st_q == ST_XFER);
  assign upd_o = aen_o;
  assign ch_o  = ch_q;
endmodule

// File: rtl/dma4_engine.sv
module dma4_engine
  import dma4_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         reg_wr_i,
  input  logic [$clog2(NUM_CH)+1:0]    reg_addr_i,
  input  logic [DATA_W-1:0]            reg_wdata_i,
  input  logic [NUM_CH-1:0]            dreq_ni,
  output logic [NUM_CH-1:0]            dack_no,
  output logic                         hrq_o,
  input  logic                         hlda_i,
  output logic                         aen_o,
  output logic [2*DATA_W-1:0]          addr_o,
  output logic                         mem_rd_o,
  output logic                         mem_wr_o,
  output logic                         io_rd_o,
  output logic                         io_wr_o,
  output logic                         tc_o,
  output logic [NUM_CH-1:0]            status_o
);
  localparam int CH_W   = $clog2(NUM_CH);
  localparam int ADDR_W = 2 * DATA_W;

  logic [NUM_CH-1:0][ADDR_W-1:0] cur_a, cur_c;
  logic [NUM_CH-1:0]             dir, mask, pend;
  logic                          rot, pend_any, xfer, upd;
  logic [CH_W-1:0]               win, ch;

  dma4_regs #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_regs (
    .clk_i, .rst_ni,
    .wr_i(reg_wr_i), .waddr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .upd_i(upd), .upd_ch_i(ch),
    .cur_addr_o(cur_a), .cur_cnt_o(cur_c), .dir_o(dir),
    .mask_o(mask), .rotate_o(rot), .status_o(status_o)
  );

  assign pend = ~dreq_ni & ~mask;

  dma4_arb #(.NUM_CH(NUM_CH)) u_arb (
    .clk_i, .rst_ni,
    .req_i(pend), .rotate_i(rot), .adv_i(upd), .adv_ch_i(ch),
    .valid_o(pend_any), .win_o(win)
  );

  dma4_seq #(.NUM_CH(NUM_CH)) u_seq (
    .clk_i, .rst_ni,
    .pend_i(pend_any), .win_i(win), .hlda_i,
    .hrq_o, .aen_o(xfer), .ch_o(ch), .upd_o(upd)
  );

  assign aen_o    = xfer;
  assign addr_o   = xfer ? cur_a[ch] : '0;
  assign tc_o     = xfer && (cur_c[ch] == '0);
  assign mem_rd_o = xfer &&  dir[ch];
  assign io_wr_o  = xfer &&  dir[ch];
  assign mem_wr_o = xfer && !dir[ch];
  assign io_rd_o  = xfer && !dir[ch];

  always_comb begin
    dack_no = '1;
    if (xfer) dack_no[ch] = 1'b0;
  end
endmodule

// File: rtl/dma4_engine_chk.sv
module dma4_engine_chk #(
  parameter int NUM_CH = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_wr_i,
  input logic [NUM_CH-1:0] dack_no,
  input logic              hrq_o,
  input logic              hlda_i,
  input logic              aen_o,
  input logic              mem_rd_o,
  input logic              mem_wr_o,
  input logic              io_rd_o,
  input logic              io_wr_o,
  input logic              tc_o,
  input logic [NUM_CH-1:0] status_o
);
  AST_DACK_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~dack_no)); // R1
  AST_DACK_IN_XFER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dack_no != '1) |-> aen_o); // R1
  AST_AEN_AFTER_HLDA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(aen_o) |-> ($past(hlda_i) && $past(hrq_o))); // R2
  AST_AEN_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aen_o |=> !aen_o); // R2
  AST_TC_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o |-> (aen_o && $countones(~dack_no) == 1)); // R6
  AST_TC_SETS_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tc_o && !reg_wr_i) |=> ((status_o & $past(~dack_no)) != '0)); // R6
  AST_STROBE_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aen_o |-> ((mem_rd_o ^ mem_wr_o) && (io_rd_o ^ io_wr_o) && (mem_rd_o == io_wr_o))); // R9
  AST_STROBE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !aen_o |-> !(mem_rd_o || mem_wr_o || io_rd_o || io_wr_o)); // R9
  AST_HOLD_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aen_o |=> !hrq_o); // R10
endmodule

bind dma4_engine dma4_engine_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_wr_i(reg_wr_i), .dack_no(dack_no),
  .hrq_o(hrq_o), .hlda_i(hlda_i), .aen_o(aen_o), .mem_rd_o(mem_rd_o),
  .mem_wr_o(mem_wr_o), .io_rd_o(io_rd_o), .io_wr_o(io_wr_o), .tc_o(tc_o),
  .status_o(status_o)
);

// File: tb/dma4_engine_bench.sv
`timescale 1ns/1ps
module dma4_engine_bench;
  localparam int NCH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [3:0]  dreq_n = '1;
  logic [3:0]  dack_n;
  logic        hrq, hlda, aen, mem_rd, mem_wr, io_rd, io_wr, tc;
  logic [15:0] addr;
  logic [3:0]  status;

  int n_tests = 0;
  int n_fail  = 0;
  int last_ch = 3;
  logic [15:0] exp_addr [NCH];

  always #10 clk = ~clk;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) hlda <= 1'b0;
    else        hlda <= hrq;

  dma4_engine u_dma4_engine (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .dreq_ni(dreq_n), .dack_no(dack_n), .hrq_o(hrq),
    .hlda_i(hlda), .aen_o(aen), .addr_o(addr), .mem_rd_o(mem_rd),
    .mem_wr_o(mem_wr), .io_rd_o(io_rd), .io_wr_o(io_wr), .tc_o(tc),
    .status_o(status)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic prog(input int ch, input logic [15:0] a, input logic [15:0] c,
                      input logic [2:0] mode);
    wr(4'd13, 8'h00);
    wr(4'(ch), a[7:0]);      wr(4'(ch), a[15:8]);
    wr(4'(4 + ch), c[7:0]);  wr(4'(4 + ch), c[15:8]);
    wr(4'(8 + ch), {5'b0, mode});
  endtask

  task automatic wait_xfer(output bit found);
    found = 1'b0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (aen) begin found = 1'b1; break; end
    end
  endtask

  // returns at the falling edge inside the transfer cycle
  task automatic xfer(input string req, input int ch, input logic [15:0] ea,
                      input bit etc, input bit dir);
    bit found;
    wait_xfer(found);
    chk(found, req, "transfer seen", int'(found), 1);
    if (found) begin
      chk(dack_n == ~(4'b1 << ch), "R1", "dack", int'(dack_n), int'(~(4'b1 << ch) & 4'hF));
      chk(addr == ea, req, "addr", int'(addr), int'(ea));
      chk(tc == etc, "R6", "tc", int'(tc), int'(etc));
      chk({mem_rd, io_wr, mem_wr, io_rd} == (dir ? 4'b1100 : 4'b0011), "R9", "strobes",
          int'({mem_rd, io_wr, mem_wr, io_rd}), dir ? 12 : 3);
      last_ch = ch;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; dreq_n = '1; reg_wr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    last_ch = 3;
    @(negedge clk);
  endtask

  function automatic int pick(input logic [3:0] pat, input bit rot, input int last);
    int s;
    s = rot ? (last + 1) % NCH : 0;
    for (int k = 0; k < NCH; k++)
      if (pat[(s + k) % NCH]) return (s + k) % NCH;
    return 0;
  endfunction

  task automatic sweep(input bit rot, input string req);
    for (int p = 1; p < 16; p++) begin
      int w;
      w = pick(4'(p), rot, last_ch);
      dreq_n = ~4'(p);
      xfer(req, w, exp_addr[w], 1'b0, w[0]);
      exp_addr[w] = exp_addr[w] + 16'd1;
      dreq_n = '1;
      @(negedge clk);
      chk(!hrq, "R10", "hrq after transfer", int'(hrq), 0);
      repeat (2) @(negedge clk);
    end
  endtask

  initial begin
    #3ms;
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    chk(!hrq && !aen && dack_n == 4'hF && !tc, "R2", "reset outputs",
        int'({hrq, aen, dack_n, tc}), 16'h3C >> 1);
    chk(status == 4'h0, "R6", "reset status", int'(status), 0);
    chk({mem_rd, mem_wr, io_rd, io_wr} == 4'h0, "R9", "reset strobes",
        int'({mem_rd, mem_wr, io_rd, io_wr}), 0);
    dreq_n = '0;
    repeat (10) @(negedge clk);
    chk(!hrq, "R11", "masked at reset", int'(hrq), 0);
    dreq_n = '1;

    // R3 fixed priority sweep, R5 increment tracking
    for (int i = 0; i < NCH; i++) begin
      prog(i, 16'(i * 16'h1000), 16'h00FF, {2'b00, 1'(i)});
      exp_addr[i] = 16'(i * 16'h1000);
    end
    wr(4'd12, 8'h00);
    wr(4'd14, 8'h00);
    sweep(1'b0, "R3");

    // R4 rotating priority sweep and held-request rotation
    wr(4'd12, 8'h01);
    sweep(1'b1, "R4");
    dreq_n = 4'b0000;
    for (int t = 0; t < 8; t++) begin
      int w;
      w = pick(4'hF, 1'b1, last_ch);
      xfer("R4", w, exp_addr[w], 1'b0, w[0]);
      exp_addr[w] = exp_addr[w] + 16'd1;
      @(negedge clk);
      chk(!hrq, "R10", "hrq released", int'(hrq), 0);
    end
    dreq_n = '1;

    // R4 reset restarts the rotation at channel 0
    do_reset();
    prog(0, 16'h0100, 16'h00FF, 3'b000);
    prog(1, 16'h0200, 16'h00FF, 3'b001);
    wr(4'd12, 8'h01);
    wr(4'd14, 8'h0C);
    dreq_n = 4'b1100;
    xfer("R4", 0, 16'h0100, 1'b0, 1'b0);
    xfer("R4", 1, 16'h0200, 1'b0, 1'b1);
    xfer("R4", 0, 16'h0101, 1'b0, 1'b0);
    dreq_n = '1;

    // R5 wrap upward and R6 terminal count masks the channel
    do_reset();
    prog(0, 16'hFFFE, 16'h0003, 3'b000);
    wr(4'd14, 8'h0E);
    dreq_n = 4'b1110;
    xfer("R5", 0, 16'hFFFE, 1'b0, 1'b0);
    xfer("R5", 0, 16'hFFFF, 1'b0, 1'b0);
    xfer("R5", 0, 16'h0000, 1'b0, 1'b0);
    xfer("R6", 0, 16'h0001, 1'b1, 1'b0);
    @(negedge clk);
    chk(status == 4'b0001, "R6", "status after tc", int'(status), 1);
    repeat (10) @(negedge clk);
    chk(!hrq, "R6", "masked after tc", int'(hrq), 0);
    dreq_n = '1;
    wr(4'd8, 8'h00);
    chk(status == 4'b0000, "R13", "status cleared", int'(status), 0);

    // R5 decrement with downward wrap
    prog(1, 16'h0001, 16'h0002, 3'b011);
    wr(4'd14, 8'h0D);
    dreq_n = 4'b1101;
    xfer("R5", 1, 16'h0001, 1'b0, 1'b1);
    xfer("R5", 1, 16'h0000, 1'b0, 1'b1);
    xfer("R6", 1, 16'hFFFF, 1'b1, 1'b1);
    dreq_n = '1;

    // R7 auto-initialization reload
    prog(2, 16'h1234, 16'h0001, 3'b101);
    wr(4'd14, 8'h0B);
    dreq_n = 4'b1011;
    xfer("R7", 2, 16'h1234, 1'b0, 1'b1);
    xfer("R7", 2, 16'h1235, 1'b1, 1'b1);
    xfer("R7", 2, 16'h1234, 1'b0, 1'b1);
    xfer("R7", 2, 16'h1235, 1'b1, 1'b1);
    xfer("R7", 2, 16'h1234, 1'b0, 1'b1);
    dreq_n = '1;
    @(negedge clk);
    chk(status[2], "R7", "status set on reload", int'(status[2]), 1);

    // R8 byte pointer clear
    wr(4'd3, 8'h11);
    wr(4'd13, 8'h00);
    wr(4'd3, 8'h40);
    wr(4'd3, 8'h3C);
    wr(4'd7, 8'h10);
    wr(4'd7, 8'h00);
    wr(4'd11, 8'h00);
    wr(4'd14, 8'h07);
    dreq_n = 4'b0111;
    xfer("R8", 3, 16'h3C40, 1'b0, 1'b0);

    // R12 CPU write collides with the transfer update
    xfer("R5", 3, 16'h3C41, 1'b0, 1'b0);
    reg_wr = 1'b1; reg_addr = 4'd3; reg_wdata = 8'h80;
    @(negedge clk);
    reg_wr = 1'b0;
    xfer("R12", 3, 16'h3C80, 1'b0, 1'b0);
    xfer("R12", 3, 16'h3C81, 1'b0, 1'b0);
    dreq_n = '1;

    // R2 no transfer while hold acknowledge is withheld
    do_reset();
    prog(0, 16'h0050, 16'h0010, 3'b000);
    wr(4'd14, 8'h0E);
    force hlda = 1'b0;
    dreq_n = 4'b1110;
    repeat (12) @(negedge clk);
    chk(hrq && !aen && dack_n == 4'hF, "R2", "wait for hlda",
        int'({hrq, aen, dack_n}), 6'h2F);
    release hlda;
    xfer("R2", 0, 16'h0050, 1'b0, 1'b0);
    dreq_n = '1;

    repeat (4) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule